// File: doc/BRIEF.md
# Ethernet Receive Destination-Address Filter

This block watches the opening bytes of every received Ethernet frame and decides whether the frame is kept. The receive path hands it one byte per valid beat together with a start-of-frame flag. The first six bytes form the destination address, and the first of them is sent first. Once the sixth byte is in, the block raises a one-cycle done strobe and, in the same cycle, its pass/drop verdict.

The verdict comes from several sources. Unicast destinations are compared against a bank of exact-match address entries, and each entry can be enabled on its own. Group destinations are looked up in a 64-bin hash table. The bin index is six bits drawn from the Ethernet CRC-32 of the address, which is computed one byte per beat while the address streams in. Broadcast normally passes and can be blocked. Override modes let every frame through, or every group frame through. Configuration is written through a small write-only register port into shadow storage. The filter copies that storage into its working set at each start of frame, so a frame is always judged against one consistent configuration.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: In hash mode (mode bit 2 set), a group frame that is not broadcast passes only when the hash table bit it indexes is 1. The index is 6 bits: run the reflected CRC-32 (polynomial 0xEDB88320, start value all ones, each byte least significant bit first) over the six address bytes, invert the result, bit-reverse it, and take the top six bits.
- R2: Bit 5 of the hash index picks the table word: 1 selects the high word (register 2) and 0 the low word (register 1). Bits 4..0 pick the bit within that word.
- R3: With mode bit 0 (promiscuous) set, every frame passes.
- R4: With mode bit 1 (all-group) set, every group frame passes without a table lookup. Writing all ones into both hash words gives the same result in hash mode.
- R5: A unicast frame passes when its destination equals an enabled exact-match entry. Entry i sits at register 16+2i, which holds address bytes 0..3 with byte 0 in bits 7:0, and at register 17+2i, which holds bytes 4 and 5 in bits 15:0 and the enable in bit 31. Entry 0 is the station address. There are 16 entries by default and the count can be set to 32.
- R6: A disabled entry never matches. A unicast frame that matches no enabled entry is dropped, unless an override applies.
- R7: With mode bit 3 (receive-all) set, every frame passes.
- R8: The all-ones broadcast address passes unless mode bit 4 (broadcast block) is set, in which case it is dropped unless bit 0 or bit 3 is set. A destination is a group address when bit 0 of its first byte is 1.
- R9: The done output is a single-cycle pulse in the cycle right after the sixth address byte is accepted. The pass output carries the verdict in that cycle and is 0 in every other cycle. Both are 0 after reset.
- R10: A register write is used first by the frame whose start-of-frame beat comes after the write cycle. A write during a frame, or in the same cycle as its start-of-frame beat, does not affect that frame.
- R11: Cycles with rx_valid low are ignored. A start-of-frame beat restarts address collection, even in the middle of an address. Bytes after the sixth produce no further decision until the next start of frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | Marks the first byte of a frame (qualified by rx_valid) |
| rx_byte | input | 8 | Receive byte |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register index |
| cfg_wdata | input | 32 | Register write data |
| flt_done | output | 1 | One-cycle decision strobe |
| flt_pass | output | 1 | Verdict, valid with flt_done |

## Verification
A register write can land in the same cycle as a start-of-frame beat. It can also land between two address bytes of a frame that is being collected. The bench provokes both cases. It drives the write strobe at the same negative edge as the first byte, and in a separate case it drives the write in a stall cycle in the middle of the address. Each time, the verdict for the current frame must reflect the earlier configuration, and the verdict for the following frame must reflect the new one. Group-address checks also place a single set bit in the correct table word and then in the wrong one, which separates the word select from the bit select.

// File: rtl/afl_pkg.sv
package afl_pkg;

  localparam int CFG_DW      = 32;
  localparam int REG_MODE    = 0;
  localparam int REG_HASH_LO = 1;
  localparam int REG_HASH_HI = 2;
  localparam int REG_PM_BASE = 16;
  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;

  typedef struct packed {
    logic bcast_blk;
    logic recv_all;
    logic hash_en;
    logic all_group;
    logic promisc;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  // One byte of the reflected CRC, least significant bit first.
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int j = 0; j < 8; j++) begin
      if (r[0] ^ b[j]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/afl_cfg_bank.sv
module afl_cfg_bank
  import afl_pkg::*;
#(
  parameter int NUM_PM = 16,
  parameter int CFG_AW = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [CFG_AW-1:0]       wr_addr,
  input  logic [CFG_DW-1:0]       wr_data,
  input  logic                    load,
  output mode_t                   act_mode,
  output logic [63:0]             act_hash,
  output logic [NUM_PM-1:0][47:0] act_pm_addr,
  output logic [NUM_PM-1:0]       act_pm_en
);

  localparam logic [CFG_AW-1:0] A_MODE = CFG_AW'(REG_MODE);
  localparam logic [CFG_AW-1:0] A_HLO  = CFG_AW'(REG_HASH_LO);
  localparam logic [CFG_AW-1:0] A_HHI  = CFG_AW'(REG_HASH_HI);

  mode_t       sh_mode;
  logic [31:0] sh_hash_lo;
  logic [31:0] sh_hash_hi;

  logic sel_mode, sel_hlo, sel_hhi;

  always_comb begin
    sel_mode = wr_en && (wr_addr == A_MODE);
    sel_hlo  = wr_en && (wr_addr == A_HLO);
    sel_hhi  = wr_en && (wr_addr == A_HHI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh_mode <= '0;
    else if (sel_mode) sh_mode <= mode_t'(wr_data[MODE_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sh_hash_lo <= '0;
    else if (sel_hlo) sh_hash_lo <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sh_hash_hi <= '0;
    else if (sel_hhi) sh_hash_hi <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_mode <= '0;
      act_hash <= '0;
    end else if (load) begin
      act_mode <= sh_mode;
      act_hash <= {sh_hash_hi, sh_hash_lo};
    end
  end

  for (genvar i = 0; i < NUM_PM; i++) begin : g_entry
    localparam logic [CFG_AW-1:0] A_LO = CFG_AW'(REG_PM_BASE + 2*i);
    localparam logic [CFG_AW-1:0] A_HI = CFG_AW'(REG_PM_BASE + 2*i + 1);

    logic [47:0] sh_addr;
    logic        sh_en;
    logic        sel_lo, sel_hi;

    always_comb begin
      sel_lo = wr_en && (wr_addr == A_LO);
      sel_hi = wr_en && (wr_addr == A_HI);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sh_addr[31:0] <= '0;
      else if (sel_lo) sh_addr[31:0] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_addr[47:32] <= '0;
        sh_en          <= 1'b0;
      end else if (sel_hi) begin
        sh_addr[47:32] <= wr_data[15:0];
        sh_en          <= wr_data[31];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_pm_addr[i] <= '0;
        act_pm_en[i]   <= 1'b0;
      end else if (load) begin
        act_pm_addr[i] <= sh_addr;
        act_pm_en[i]   <= sh_en;
      end
    end
  end

endmodule

// File: rtl/afl_crc_hash.sv
module afl_crc_hash
  import afl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       beat,
  input  logic       first,
  input  logic [7:0] din,
  output logic [5:0] idx_now
);

  logic [31:0] crc_q;
  logic [31:0] crc_nxt;
  logic [31:0] crc_base;

  always_comb begin
    crc_base = first ? 32'hFFFF_FFFF : crc_q;
    crc_nxt  = crc_step(crc_base, din);
    for (int j = 0; j < 6; j++) begin
      idx_now[5-j] = ~crc_nxt[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= 32'hFFFF_FFFF;
    else if (beat) crc_q <= crc_nxt;
  end

endmodule

// File: rtl/afl_perfect_match.sv
module afl_perfect_match #(
  parameter int NUM_PM = 16
) (
  input  logic [47:0]             da,
  input  logic [NUM_PM-1:0][47:0] pm_addr,
  input  logic [NUM_PM-1:0]       pm_en,
  output logic                    hit
);

  logic [NUM_PM-1:0] eq;

  for (genvar i = 0; i < NUM_PM; i++) begin : g_cmp
    assign eq[i] = pm_en[i] && (pm_addr[i] == da);
  end

  assign hit = |eq;

endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
  import afl_pkg::*;
#(
  parameter int NUM_PM = 16,
  parameter int CFG_AW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic [7:0]        rx_byte,
  input  logic              cfg_wr_en,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic              flt_done,
  output logic              flt_pass
);

  localparam int BYTES    = 6;
  localparam int CNT_W    = $clog2(BYTES + 1);
  localparam int STORED_W = 8 * (BYTES - 1);

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  // Configuration
  mode_t                   act_mode;
  logic [63:0]             act_hash;
  logic [NUM_PM-1:0][47:0] act_pm_addr;
  logic [NUM_PM-1:0]       act_pm_en;
  logic                    beat_first;

  afl_cfg_bank #(.NUM_PM(NUM_PM), .CFG_AW(CFG_AW)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_en       (cfg_wr_en),
    .wr_addr     (cfg_addr),
    .wr_data     (cfg_wdata),
    .load        (beat_first),
    .act_mode    (act_mode),
    .act_hash    (act_hash),
    .act_pm_addr (act_pm_addr),
    .act_pm_en   (act_pm_en)
  );

  // Address collection
  logic [CNT_W-1:0]    cnt_q, cnt_nxt;
  logic [STORED_W-1:0] da_q, da_nxt;
  logic                beat_more, beat_any, beat_last;
  logic [CNT_W-1:0]    byte_idx;

  always_comb begin
    beat_first = rx_valid && rx_sof;
    beat_more  = rx_valid && !rx_sof && (cnt_q != '0);
    beat_any   = beat_first || beat_more;
    byte_idx   = beat_first ? '0 : cnt_q;
    beat_last  = beat_more && (cnt_q == CNT_W'(BYTES - 1));

    cnt_nxt = cnt_q;
    if (beat_last)     cnt_nxt = '0;
    else if (beat_any) cnt_nxt = byte_idx + 1'b1;

    da_nxt = da_q;
    for (int k = 0; k < BYTES - 1; k++) begin
      if (beat_any && (byte_idx == CNT_W'(k))) da_nxt[8*k +: 8] = rx_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cnt_q <= '0;
      da_q  <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      da_q  <= da_nxt;
    end
  end

  // Hash index
  logic [5:0] hash_idx;

  afl_crc_hash u_crc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .beat    (beat_any),
    .first   (beat_first),
    .din     (rx_byte),
    .idx_now (hash_idx)
  );

  // Exact match
  logic [47:0] da_full;
  logic        pm_hit;

  assign da_full = {rx_byte, da_q};

  afl_perfect_match #(.NUM_PM(NUM_PM)) u_pm (
    .da      (da_full),
    .pm_addr (act_pm_addr),
    .pm_en   (act_pm_en),
    .hit     (pm_hit)
  );

  // Verdict
  logic is_group, is_bcast, hash_bit, pass_nxt;
  logic done_d, pass_d;

  always_comb begin
    is_group = da_full[0];
    is_bcast = &da_full;
    hash_bit = act_hash[hash_idx];
    if (act_mode.recv_all || act_mode.promisc) pass_nxt = 1'b1;
    else if (is_bcast)                         pass_nxt = !act_mode.bcast_blk;
    else if (is_group)                         pass_nxt = act_mode.all_group ||
                                                          (act_mode.hash_en && hash_bit);
    else                                       pass_nxt = pm_hit;
    done_d = beat_last;
    pass_d = beat_last && pass_nxt;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      flt_done <= 1'b0;
      flt_pass <= 1'b0;
    end else begin
      flt_done <= done_d;
      flt_pass <= pass_d;
    end
  end

endmodule

// File: rtl/afl_checker.sv
module afl_checker
  import afl_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  rx_valid,
  input logic  rx_sof,
  input logic  done,
  input logic  pass,
  input mode_t mode
);

  // R9: the strobe lasts one cycle
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: the verdict is 0 outside the strobe
  assert_pass_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !pass);

  // R11: a decision follows an accepted beat
  assert_done_after_beat_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rx_valid));

  // R3: promiscuous working mode forces a pass
  assert_promisc_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(mode.promisc)) |-> pass);

  // R7: receive-all forces a pass
  assert_recv_all_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(mode.recv_all)) |-> pass);

  // R10: the working configuration moves only at a start-of-frame beat
  assert_cfg_at_sof_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |-> $past(rx_valid && rx_sof));

endmodule

bind eth_rx_addr_filter afl_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .rx_valid (rx_valid),
  .rx_sof   (rx_sof),
  .done     (flt_done),
  .pass     (flt_pass),
  .mode     (act_mode)
);

// File: tb/sim_eth_rx_addr_filter.sv
`timescale 1ns/1ps
module sim_eth_rx_addr_filter;

  localparam int NPM = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_valid, rx_sof, cfg_wr_en;
  logic [7:0] rx_byte;
  logic [6:0] cfg_addr;
  logic [31:0] cfg_wdata;
  logic       flt_done, flt_pass;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  eth_rx_addr_filter u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_byte(rx_byte), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .flt_done(flt_done), .flt_pass(flt_pass)
  );

  // Bench copy of the programmed configuration (byte 0 at [47:40])
  logic [47:0] tb_pm   [NPM];
  logic        tb_pm_en[NPM];
  logic [63:0] tb_hash;

  function automatic logic [5:0] ref_idx(input logic [47:0] da);
    logic [31:0] c, v, rev;
    logic [7:0]  b;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++) begin
      b = da[47-8*k -: 8];
      for (int j = 0; j < 8; j++) begin
        logic fb;
        fb = c[0] ^ b[j];
        c  = c >> 1;
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    end
    v = ~c;
    for (int j = 0; j < 32; j++) rev[31-j] = v[j];
    return rev[31:26];
  endfunction

  function automatic logic ref_pass(input logic [47:0] da, input logic [4:0] m);
    logic hit;
    if (m[3] || m[0]) return 1'b1;
    if (&da) return !m[4];
    if (da[40]) return m[1] || (m[2] && tb_hash[ref_idx(da)]);
    hit = 1'b0;
    for (int i = 0; i < NPM; i++) if (tb_pm_en[i] && tb_pm[i] == da) hit = 1'b1;
    return hit;
  endfunction

  function automatic string tag_of(input logic [47:0] da, input logic [4:0] m);
    if (m[3]) return "R7";
    if (m[0]) return "R3";
    if (&da) return "R8";
    if (da[40]) return m[1] ? "R4" : "R1";
    return "R5";
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; cfg_wr_en = 1'b0;
  endtask

  task automatic beat(input logic [7:0] b, input logic s);
    @(negedge clk);
    rx_valid = 1'b1; rx_sof = s; rx_byte = b; cfg_wr_en = 1'b0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0;
    cfg_wr_en = 1'b1; cfg_addr = 7'(a); cfg_wdata = d;
  endtask

  task automatic set_mode(input logic [4:0] m);
    wr(0, {27'd0, m});
  endtask

  task automatic set_hash(input logic [63:0] h);
    tb_hash = h;
    wr(1, h[31:0]);
    wr(2, h[63:32]);
  endtask

  task automatic set_pm(input int i, input logic [47:0] da, input logic en);
    tb_pm[i] = da; tb_pm_en[i] = en;
    wr(16 + 2*i, {da[23:16], da[31:24], da[39:32], da[47:40]});
    wr(17 + 2*i, {en, 15'd0, da[7:0], da[15:8]});
  endtask

  // Sends one address; returns the outputs seen in the cycle after byte 6.
  task automatic frame(input logic [47:0] da, input int gap, output logic d, output logic p);
    for (int k = 0; k < 6; k++) begin
      beat(da[47-8*k -: 8], k == 0);
      if (k < 5) repeat (gap) idle();
    end
    idle();
    d = flt_done; p = flt_pass;
  endtask

  localparam logic [47:0] STA  = 48'h02_11_22_33_44_55;
  localparam logic [47:0] UC1  = 48'h02_AA_BB_CC_DD_01;
  localparam logic [47:0] UCX  = 48'h02_00_00_00_00_77;
  localparam logic [47:0] MISS = 48'h02_11_22_33_44_56;
  localparam logic [47:0] MC1  = 48'h01_00_5E_00_00_01;
  localparam logic [47:0] MC2  = 48'h33_33_00_00_00_01;
  localparam logic [47:0] MC3  = 48'h01_80_C2_00_00_0E;
  localparam logic [47:0] BC   = 48'hFF_FF_FF_FF_FF_FF;

  localparam int NV = 16;
  localparam logic [52:0] VEC [NV] = '{
    {5'h00, STA}, {5'h00, UC1}, {5'h00, UCX}, {5'h00, MISS},
    {5'h01, MISS}, {5'h02, MC1}, {5'h00, MC1}, {5'h00, BC},
    {5'h10, BC},  {5'h11, BC},  {5'h08, MISS}, {5'h04, MC1},
    {5'h04, MC2}, {5'h04, MC3}, {5'h14, BC},  {5'h18, MC2}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic d, p;
    logic [5:0] ix;
    logic [63:0] h;
    int ndone;
    for (int i = 0; i < NPM; i++) begin tb_pm[i] = '0; tb_pm_en[i] = 1'b0; end
    tb_hash = '0;
    rst_n = 1'b0; rx_valid = 0; rx_sof = 0; rx_byte = 0;
    cfg_wr_en = 0; cfg_addr = 0; cfg_wdata = 0;
    repeat (3) @(negedge clk);
    check("R9", flt_done, 1'b0, "done in reset");
    check("R9", flt_pass, 1'b0, "pass in reset");
    rst_n = 1'b1;
    repeat (3) idle();
    check("R9", flt_done, 1'b0, "done after reset");

    set_pm(0, STA, 1'b1);
    set_pm(1, UC1, 1'b1);
    set_pm(2, UCX, 1'b0);
    set_hash(64'h0F0F_3C3C_A5A5_5A5A);

    // Vector walk
    for (int v = 0; v < NV; v++) begin
      logic [47:0] da;
      logic [4:0]  m;
      {m, da} = VEC[v];
      set_mode(m);
      frame(da, v % 3, d, p);
      check("R9", d, 1'b1, $sformatf("vector %0d done", v));
      check(tag_of(da, m), p, ref_pass(da, m), $sformatf("vector %0d verdict", v));
      idle();
      check("R9", flt_done, 1'b0, $sformatf("vector %0d done width", v));
    end

    // R1 / R2: one set bit, right word then wrong word
    set_mode(5'h04);
    ix = ref_idx(MC2);
    h = 64'd1 << ix;
    set_hash(h);
    frame(MC2, 0, d, p);
    check("R1", p, 1'b1, "only own bin set");
    set_hash(64'd1 << {~ix[5], ix[4:0]});
    frame(MC2, 0, d, p);
    check("R2", p, 1'b0, "bit set in other word");
    set_hash(~h);
    frame(MC2, 0, d, p);
    check("R1", p, 1'b0, "all bins but own set");
    set_hash({64{1'b1}});
    frame(MC3, 1, d, p);
    check("R4", p, 1'b1, "full table in hash mode");
    set_hash(64'd0);
    frame(MC3, 0, d, p);
    check("R1", p, 1'b0, "empty table");

    // R6: enable off on the station entry
    set_mode(5'h00);
    set_pm(0, STA, 1'b0);
    frame(STA, 0, d, p);
    check("R6", p, 1'b0, "disabled station entry");
    set_pm(0, STA, 1'b1);
    frame(STA, 0, d, p);
    check("R5", p, 1'b1, "station entry re-enabled");

    // R10: write in the start-of-frame cycle
    set_mode(5'h01);
    frame(MISS, 0, d, p);
    check("R3", p, 1'b1, "promiscuous before change");
    @(negedge clk);
    rx_valid = 1; rx_sof = 1; rx_byte = MISS[47:40];
    cfg_wr_en = 1; cfg_addr = 7'd0; cfg_wdata = 32'd0;
    for (int k = 1; k < 6; k++) beat(MISS[47-8*k -: 8], 1'b0);
    idle();
    check("R10", flt_pass, 1'b1, "write in sof cycle not used");
    frame(MISS, 0, d, p);
    check("R10", p, 1'b0, "write used by next frame");

    // R10: write in the middle of an address
    beat(MISS[47:40], 1'b1);
    beat(MISS[39:32], 1'b0);
    set_mode(5'h01);
    for (int k = 2; k < 6; k++) beat(MISS[47-8*k -: 8], 1'b0);
    idle();
    check("R10", flt_pass, 1'b0, "mid-frame write not used");
    frame(MISS, 2, d, p);
    check("R10", p, 1'b1, "mid-frame write used next frame");

    // R11: restart mid-address, then payload bytes
    set_mode(5'h00);
    beat(8'hFF, 1'b1);
    beat(8'hFF, 1'b0);
    idle();
    beat(8'hFF, 1'b0);
    ndone = 0;
    for (int k = 0; k < 6; k++) begin
      beat(UC1[47-8*k -: 8], k == 0);
      if (flt_done) ndone++;
    end
    idle();
    check("R11", flt_pass, 1'b1, "restarted address verdict");
    if (flt_done) ndone++;
    for (int k = 0; k < 8; k++) begin
      beat(8'hFF, 1'b0);
      if (flt_done) ndone++;
    end
    idle();
    if (flt_done) ndone++;
    check("R11", 1'(ndone == 1), 1'b1, "exactly one decision per frame");

    ended = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule